// File: doc/BRIEF.md
# Three-Stage Predicated Pipeline with Exposed Program Counter

This block is a small in-order core for a toy instruction set. It has three stages: fetch, decode and execute. It keeps sixteen 32-bit registers and four condition flags. It fetches from an instruction memory that answers in the same cycle. Each instruction that reaches execute is reported on a commit port, which the surrounding logic uses to follow the architectural writes. Two instruction modes exist: a 32-bit wide mode and a 16-bit compact mode. A branch-and-exchange instruction switches between them.

The defining behaviour is the value an instruction sees when it reads the program counter. That value is taken from the live fetch address rather than from the instruction's own address. Because the block has three stages, this places it two instructions ahead. In compact mode, instructions outside the branch class also see that value rounded down to a word boundary.

Every instruction is predicated. An instruction whose condition fails moves through execute as a bubble and causes no redirect. A taken branch discards the two younger stages and refills them.

Top module: `tri_stage_core`

## Requirements
- R1: Suppose an instruction is fetched from address A in cycle t, and no redirect occurs in cycle t or t+1. Then it occupies execute in cycle t+2, with `ret_valid`=1 and `ret_addr`=A.
- R2: In wide mode, an executing instruction that reads the program counter sees its own address plus 8. This applies when source register index 15 is used, and to the base of ADR. A write aimed at register 15 is discarded.
- R3: In compact mode, the branch-class operations (B=6, BL=7, CBZ=9, CBNZ=10) see the program counter as their address plus 4. Their 4-bit offset is sign-extended and doubled. CBZ branches when the register is zero; CBNZ branches when it is nonzero.
- R4: In compact mode, every other operation that reads the program counter sees its address plus 4 with bit 1 forced to 0.
- R5: The 4-bit condition codes are: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear, 8 C set and Z clear, 9 C clear or Z set, 10 N equals V, 11 N differs from V, 12 Z clear and N equals V, 13 Z set or N differs from V, 14 always, 15 never. When the condition fails, the instruction retires with `ret_exec`=0. It then writes no register, leaves the flags unchanged and does not redirect fetch.
- R6: After a taken branch in execute, `ret_valid` is 0 for exactly two cycles. The branch target executes in the third cycle.
- R7: While fetching and not redirected, `imem_addr` advances by 4 per cycle in wide mode and by 2 per cycle in compact mode.
- R8: Reset is synchronous and active-low. After reset, `imem_addr`=0, `imem_req`=0, `ret_valid`=0, the flags are 0, the mode is wide and all registers are 0. `imem_req` rises on the first clock after reset is released.
- R9: BL (op 7) writes register 14 with the address of the instruction that follows it. That is the branch address plus 4 in wide mode and plus 2 in compact mode.
- R10: BX (op 8) jumps to the value of its source register. If bit 0 of that value is 1, the core enters compact mode at the value with bit 0 cleared. If bit 0 is 0, it enters wide mode at the value with its low two bits cleared.
- R11: The data operations are MOVI=0 (rd = immediate, zero-extended), ADDS=1 (rd = rn + imm), SUBS=2 (rd = rn - imm), CMP=3 (flags from rn - imm) and ADR=4 (rd = PC + imm). MOVR=5 sets rd = rn. ADDS, SUBS and CMP set the flags on `flags` as N=bit 3, Z=bit 2, C=bit 1 and V=bit 0. For addition, C is the carry out. For subtraction, C means no borrow.
- R12: A wide word is laid out as cond[31:28], op[27:24], rd[23:20], rn[19:16], imm16[15:0], and imm16 is sign-extended except for MOVI. A compact halfword is cond[15:12], op[11:8], reg[7:4], low[3:0]. Here reg serves as both rd and rn, except that MOVR takes rn from low. The immediate is low, sign-extended except for MOVI. `imem_rdata` holds the little-endian word at `imem_addr`, and compact mode uses bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Fetch address |
| imem_req | output | 1 | Fetch valid |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| ret_valid | output | 1 | An instruction occupies execute |
| ret_addr | output | 32 | Address of that instruction |
| ret_exec | output | 1 | Its condition passed |
| wr_en | output | 1 | Register write this cycle |
| wr_idx | output | 4 | Register written |
| wr_data | output | 32 | Value written |
| flags | output | 4 | Current N, Z, C, V |

## Verification
Several behaviours are checked by assertions on every cycle:
- the program-counter value seen in execute, in each mode and instruction class, measured against the executing address;
- the quiet retirement of a failed-condition instruction;
- the two bubbles and the target address that follow a taken branch;
- the fetch step per mode;
- the two-cycle path from fetch to execute.

Other properties only the bench scenarios can show, because they depend on instruction semantics rather than on timing: the values actually written, the link address, the mode switch in both directions, the flag arithmetic and the fact that flushed instructions never wrote.

// File: rtl/tsc_pkg.sv
// Shared constants, decoded-instruction type and condition evaluation
// for the three-stage core. Assumes a 32-bit datapath and 4-bit fields.
package tsc_pkg;
    localparam int XLEN     = 32;
    localparam int RIDX_W   = 4;
    localparam int NREG     = 1 << RIDX_W;
    localparam int FLAG_W   = 4;
    localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(NREG - 1);
    localparam logic [RIDX_W-1:0] LR_IDX = RIDX_W'(NREG - 2);

    localparam logic [3:0] OP_MOVI = 4'd0;
    localparam logic [3:0] OP_ADDS = 4'd1;
    localparam logic [3:0] OP_SUBS = 4'd2;
    localparam logic [3:0] OP_CMP  = 4'd3;
    localparam logic [3:0] OP_ADR  = 4'd4;
    localparam logic [3:0] OP_MOVR = 4'd5;
    localparam logic [3:0] OP_B    = 4'd6;
    localparam logic [3:0] OP_BL   = 4'd7;
    localparam logic [3:0] OP_BX   = 4'd8;
    localparam logic [3:0] OP_CBZ  = 4'd9;
    localparam logic [3:0] OP_CBNZ = 4'd10;

    typedef struct packed {
        logic [3:0]        cond;
        logic [3:0]        op;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rn;
        logic [XLEN-1:0]   imm;
        logic              br_class;
    } dec_t;

    // Flag vector layout: N=3, Z=2, C=1, V=0.
    function automatic logic cond_ok(input logic [3:0] c, input logic [FLAG_W-1:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:    return z;
            4'd1:    return !z;
            4'd2:    return cy;
            4'd3:    return !cy;
            4'd4:    return n;
            4'd5:    return !n;
            4'd6:    return v;
            4'd7:    return !v;
            4'd8:    return cy && !z;
            4'd9:    return !cy || z;
            4'd10:   return n == v;
            4'd11:   return n != v;
            4'd12:   return !z && (n == v);
            4'd13:   return z || (n != v);
            4'd14:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tsc_decode.sv
// Decode stage: turns a fetched word into a decoded record, using the
// wide or compact format chosen by the current mode. Purely combinational.
module tsc_decode
    import tsc_pkg::*;
(
    input  logic [XLEN-1:0] word,
    input  logic            compact,
    output dec_t            dec
);
    logic [15:0] half;
    logic [3:0]  op_w, op_c;
    logic        br_w, br_c;

    assign half = word[15:0];
    assign op_w = word[27:24];
    assign op_c = half[11:8];
    assign br_w = (op_w == OP_B) || (op_w == OP_BL) || (op_w == OP_CBZ) || (op_w == OP_CBNZ);
    assign br_c = (op_c == OP_B) || (op_c == OP_BL) || (op_c == OP_CBZ) || (op_c == OP_CBNZ);

    // Field extraction per format.
    always_comb begin
        if (!compact) begin
            dec.cond     = word[31:28];
            dec.op       = op_w;
            dec.rd       = word[23:20];
            dec.rn       = word[19:16];
            dec.br_class = br_w;
            dec.imm      = (op_w == OP_MOVI) ? {{(XLEN-16){1'b0}}, word[15:0]}
                                             : {{(XLEN-16){word[15]}}, word[15:0]};
        end else begin
            dec.cond     = half[15:12];
            dec.op       = op_c;
            dec.rd       = half[7:4];
            dec.rn       = (op_c == OP_MOVR) ? half[3:0] : half[7:4];
            dec.br_class = br_c;
            if (op_c == OP_MOVI)
                dec.imm = {{(XLEN-4){1'b0}}, half[3:0]};
            else if (br_c)
                dec.imm = {{(XLEN-5){half[3]}}, half[3:0], 1'b0};
            else
                dec.imm = {{(XLEN-4){half[3]}}, half[3:0]};
        end
    end
endmodule

// File: rtl/tsc_regfile.sv
// Register array with one read and one write port. Synchronous
// active-low reset clears every entry. Index 15 is stored like any other
// but the core never reads or writes it.
module tsc_regfile
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]   rd_data,
    input  logic              we,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_data
);
    logic [XLEN-1:0] regs [NREG];

    // Write port with reset clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wr_idx] <= wr_data;
        end
    end

    // Asynchronous read.
    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/tsc_exec.sv
// Execute stage: evaluates the condition, computes the result, the flag
// update and any redirect. Assumes the operand already has register 15
// replaced by the program-counter read value.
module tsc_exec
    import tsc_pkg::*;
(
    input  dec_t              dec,
    input  logic              valid,
    input  logic [XLEN-1:0]   addr,
    input  logic              compact,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   pc_read,
    input  logic [FLAG_W-1:0] flags_in,
    output logic              pass,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_idx,
    output logic [XLEN-1:0]   wr_data,
    output logic              fl_we,
    output logic [FLAG_W-1:0] fl_new,
    output logic              take,
    output logic [XLEN-1:0]   target,
    output logic              new_compact
);
    logic [XLEN:0]   sum, diff;
    logic [XLEN-1:0] step, rel, rel_mask;
    logic            writes, jumps;

    assign pass     = valid && cond_ok(dec.cond, flags_in);
    assign sum      = {1'b0, opa} + {1'b0, dec.imm};
    assign diff     = {1'b0, opa} - {1'b0, dec.imm};
    assign step     = compact ? XLEN'(2) : XLEN'(4);
    assign rel_mask = compact ? ~XLEN'(1) : ~XLEN'(3);
    assign rel      = (pc_read + dec.imm) & rel_mask;

    // Operation select: result, flags and redirect.
    always_comb begin
        writes      = 1'b0;
        jumps       = 1'b0;
        wr_idx      = dec.rd;
        wr_data     = '0;
        fl_we       = 1'b0;
        fl_new      = flags_in;
        target      = rel;
        new_compact = compact;
        case (dec.op)
            OP_MOVI: begin writes = 1'b1; wr_data = dec.imm; end
            OP_ADDS: begin
                writes  = 1'b1;
                wr_data = sum[XLEN-1:0];
                fl_we   = 1'b1;
                fl_new  = {sum[XLEN-1], sum[XLEN-1:0] == '0, sum[XLEN],
                           (opa[XLEN-1] == dec.imm[XLEN-1]) && (sum[XLEN-1] != opa[XLEN-1])};
            end
            OP_SUBS, OP_CMP: begin
                writes  = (dec.op == OP_SUBS);
                wr_data = diff[XLEN-1:0];
                fl_we   = 1'b1;
                fl_new  = {diff[XLEN-1], diff[XLEN-1:0] == '0, ~diff[XLEN],
                           (opa[XLEN-1] != dec.imm[XLEN-1]) && (diff[XLEN-1] != opa[XLEN-1])};
            end
            OP_ADR:  begin writes = 1'b1; wr_data = pc_read + dec.imm; end
            OP_MOVR: begin writes = 1'b1; wr_data = opa; end
            OP_B:    jumps = 1'b1;
            OP_BL:   begin jumps = 1'b1; writes = 1'b1; wr_idx = LR_IDX; wr_data = addr + step; end
            OP_BX:   begin
                jumps       = 1'b1;
                new_compact = opa[0];
                target      = opa[0] ? (opa & ~XLEN'(1)) : (opa & ~XLEN'(3));
            end
            OP_CBZ:  jumps = (opa == '0);
            OP_CBNZ: jumps = (opa != '0);
            default: ;
        endcase
    end

    assign wr_en = pass && writes && (wr_idx != PC_IDX);
    assign take  = pass && jumps;
endmodule

// File: rtl/tri_stage_core.sv
// Top of the three-stage core. Holds fetch address, mode, the decode and
// execute pipeline registers and the flags. The program-counter read value
// is taken from the live fetch address. Assumes instruction memory answers
// in the same cycle; a taken branch empties the two younger stages.
module tri_stage_core
    import tsc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [XLEN-1:0]   imem_addr,
    output logic              imem_req,
    input  logic [XLEN-1:0]   imem_rdata,
    output logic              ret_valid,
    output logic [XLEN-1:0]   ret_addr,
    output logic              ret_exec,
    output logic              wr_en,
    output logic [RIDX_W-1:0] wr_idx,
    output logic [XLEN-1:0]   wr_data,
    output logic [FLAG_W-1:0] flags
);
    logic              run, mode;
    logic [XLEN-1:0]   fetch_pc;
    logic              d_v, e_v;
    logic [XLEN-1:0]   d_a, d_w, e_a;
    dec_t              d_dec, e_dec;
    logic [FLAG_W-1:0] flag_q;
    logic [XLEN-1:0]   pc_read, rf_q, opa, target;
    logic              take, new_mode, fl_we, e_brc;
    logic [FLAG_W-1:0] fl_new;

    tsc_decode u_dec (.word(d_w), .compact(mode), .dec(d_dec));

    tsc_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .rd_idx(e_dec.rn), .rd_data(rf_q),
        .we(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Program-counter read: live fetch address, word-aligned for compact non-branch.
    assign e_brc   = e_dec.br_class;
    assign pc_read = (mode && !e_brc) ? (fetch_pc & ~XLEN'(2)) : fetch_pc;
    assign opa     = (e_dec.rn == PC_IDX) ? pc_read : rf_q;

    tsc_exec u_ex (
        .dec(e_dec), .valid(e_v), .addr(e_a), .compact(mode), .opa(opa),
        .pc_read(pc_read), .flags_in(flag_q), .pass(ret_exec), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .fl_we(fl_we), .fl_new(fl_new),
        .take(take), .target(target), .new_compact(new_mode)
    );

    // Fetch address, mode and pipeline advance or flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            mode     <= 1'b0;
            fetch_pc <= RESET_PC;
            d_v      <= 1'b0;
            d_a      <= '0;
            d_w      <= '0;
            e_v      <= 1'b0;
            e_a      <= '0;
            e_dec    <= '0;
        end else if (!run) begin
            run <= 1'b1;
        end else if (take) begin
            fetch_pc <= target;
            mode     <= new_mode;
            d_v      <= 1'b0;
            e_v      <= 1'b0;
        end else begin
            e_v      <= d_v;
            e_a      <= d_a;
            e_dec    <= d_dec;
            d_v      <= 1'b1;
            d_a      <= fetch_pc;
            d_w      <= imem_rdata;
            fetch_pc <= fetch_pc + (mode ? XLEN'(2) : XLEN'(4));
        end
    end

    // Condition flags.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= '0;
        else if (fl_we && ret_exec) flag_q <= fl_new;
    end

    assign imem_addr = fetch_pc;
    assign imem_req  = run;
    assign ret_valid = e_v;
    assign ret_addr  = e_a;
    assign flags     = flag_q;
endmodule

// Temporal checks for tri_stage_core, attached by bind below.
module tsc_checker
    import tsc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   imem_addr,
    input logic              imem_req,
    input logic              ret_valid,
    input logic [XLEN-1:0]   ret_addr,
    input logic              ret_exec,
    input logic              wr_en,
    input logic [FLAG_W-1:0] flags,
    input logic              mode,
    input logic              br_class,
    input logic [XLEN-1:0]   pc_read,
    input logic              take,
    input logic [XLEN-1:0]   target
);
    AST_PIPE_TWO_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_req && !take) ##1 !take |=> (ret_valid && ret_addr == $past(imem_addr, 2))); // R1
    AST_PC_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !mode) |-> (pc_read == ret_addr + 32'd8)); // R2
    AST_PC_COMPACT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && mode && br_class) |-> (pc_read == ret_addr + 32'd4)); // R3
    AST_PC_COMPACT_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && mode && !br_class) |-> (pc_read == ((ret_addr + 32'd4) & ~32'd2))); // R4
    AST_SKIP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_exec) |-> (!wr_en && !take)); // R5
    AST_SKIP_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_exec) |=> (flags == $past(flags))); // R5
    AST_FLUSH_TWO_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ret_valid ##1 !ret_valid ##1 (ret_valid && ret_addr == $past(target, 3))); // R6
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_req && !take) |=> (imem_addr == $past(imem_addr) + ($past(mode) ? 32'd2 : 32'd4))); // R7
endmodule

bind tri_stage_core tsc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_req(imem_req),
    .ret_valid(ret_valid), .ret_addr(ret_addr), .ret_exec(ret_exec), .wr_en(wr_en),
    .flags(flags), .mode(mode), .br_class(e_brc), .pc_read(pc_read),
    .take(take), .target(target)
);

// File: tb/tb_tri_stage_core.sv
// Bench: behavioural instruction-level and cycle-level reference model,
// compared against the core at every falling edge, plus fixed-value checks.
module tb_tri_stage_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, ret_addr, wr_data;
    logic        imem_req, ret_valid, ret_exec, wr_en;
    logic [3:0]  wr_idx, flags;

    always #5 clk = ~clk;

    tri_stage_core dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_req(imem_req),
        .imem_rdata(imem_rdata), .ret_valid(ret_valid), .ret_addr(ret_addr),
        .ret_exec(ret_exec), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .flags(flags)
    );

    // Halfword-organised instruction memory, little-endian word read.
    logic [15:0] hmem [128];
    logic [6:0]  hi;
    assign hi = imem_addr[7:1];
    assign imem_rdata = {hmem[7'(hi + 7'd1)], hmem[hi]};

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_w(int c, int op, int rd, int rn, int imm);
        return {4'(c), 4'(op), 4'(rd), 4'(rn), 16'(imm)};
    endfunction
    function automatic logic [15:0] enc_c(int c, int op, int r, int lo);
        return {4'(c), 4'(op), 4'(r), 4'(lo)};
    endfunction
    task automatic put_w(int a, logic [31:0] w);
        hmem[a/2] = w[15:0]; hmem[a/2+1] = w[31:16];
    endtask
    task automatic put_c(int a, logic [15:0] h);
        hmem[a/2] = h;
    endtask

    // Reference state.
    bit          m_run, m_mode, mD_v, mE_v;
    logic [31:0] m_f, mD_a, mE_a;
    logic [31:0] m_regs [16];
    logic [3:0]  m_fl;
    // Evaluation results for the instruction in execute.
    bit          x_pass, x_we, x_flw, x_take, x_mode;
    logic [3:0]  x_idx, x_fl;
    logic [31:0] x_data, x_tgt;
    // Observed writes.
    logic [31:0] first_w [16];
    logic [31:0] last_w  [16];
    int          cnt_w   [16];

    function automatic bit cond_true(logic [3:0] c, logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            0: return z;          1: return !z;
            2: return cy;         3: return !cy;
            4: return n;          5: return !n;
            6: return v;          7: return !v;
            8: return cy && !z;   9: return !cy || z;
            10: return n == v;    11: return n != v;
            12: return !z && n == v;
            13: return z || n != v;
            14: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic m_eval();
        logic [31:0] w, imm, pc, av;
        logic [3:0]  c, op, rd, rn;
        logic [32:0] r;
        bit br;
        w = {hmem[7'(mE_a[7:1] + 7'd1)], hmem[mE_a[7:1]]};
        if (!m_mode) begin
            c = w[31:28]; op = w[27:24]; rd = w[23:20]; rn = w[19:16];
            imm = (op == 0) ? {16'h0, w[15:0]} : {{16{w[15]}}, w[15:0]};
            br = 0;
            pc = mE_a + 8;
        end else begin
            c = w[15:12]; op = w[11:8]; rd = w[7:4];
            rn = (op == 5) ? w[3:0] : w[7:4];
            br = (op == 6 || op == 7 || op == 9 || op == 10);
            if (op == 0) imm = {28'h0, w[3:0]};
            else if (br) imm = {{27{w[3]}}, w[3:0], 1'b0};
            else imm = {{28{w[3]}}, w[3:0]};
            pc = br ? mE_a + 4 : ((mE_a + 4) & ~32'd2);
        end
        av = (rn == 15) ? pc : m_regs[rn];
        x_pass = cond_true(c, m_fl);
        x_we = 0; x_flw = 0; x_take = 0; x_mode = m_mode; x_idx = rd;
        x_data = 0; x_fl = m_fl;
        x_tgt = (pc + imm) & (m_mode ? ~32'd1 : ~32'd3);
        case (op)
            0: begin x_we = 1; x_data = imm; end
            1: begin
                r = {1'b0, av} + {1'b0, imm};
                x_we = 1; x_data = r[31:0]; x_flw = 1;
                x_fl = {r[31], r[31:0] == 0, r[32], av[31] == imm[31] && r[31] != av[31]};
            end
            2, 3: begin
                r = {1'b0, av} - {1'b0, imm};
                x_we = (op == 2); x_data = r[31:0]; x_flw = 1;
                x_fl = {r[31], r[31:0] == 0, av >= imm, av[31] != imm[31] && r[31] != av[31]};
            end
            4: begin x_we = 1; x_data = pc + imm; end
            5: begin x_we = 1; x_data = av; end
            6: x_take = 1;
            7: begin x_take = 1; x_we = 1; x_idx = 14; x_data = mE_a + (m_mode ? 2 : 4); end
            8: begin x_take = 1; x_mode = av[0]; x_tgt = av[0] ? av & ~32'd1 : av & ~32'd3; end
            9: x_take = (av == 0);
            10: x_take = (av != 0);
            default: ;
        endcase
        if (x_idx == 15) x_we = 0;
    endtask

    task automatic m_compare();
        chk(imem_addr == m_f, "R7 fetch address", imem_addr, m_f);
        chk(imem_req == m_run, "R8 fetch valid", 32'(imem_req), 32'(m_run));
        chk(ret_valid == mE_v, "R6 execute occupancy", 32'(ret_valid), 32'(mE_v));
        chk(flags == m_fl, "R11 flags", 32'(flags), 32'(m_fl));
        if (mE_v) begin
            m_eval();
            chk(ret_addr == mE_a, "R1 execute address", ret_addr, mE_a);
            chk(ret_exec == x_pass, "R5 condition", 32'(ret_exec), 32'(x_pass));
            chk(wr_en == (x_pass && x_we), "R5 write enable", 32'(wr_en), 32'(x_pass && x_we));
            if (x_pass && x_we) begin
                chk(wr_idx == x_idx, "R2 write index", 32'(wr_idx), 32'(x_idx));
                chk(wr_data == x_data, "R2 write data", wr_data, x_data);
            end
        end else begin
            chk(wr_en == 0, "R6 no write in bubble", 32'(wr_en), 0);
        end
    endtask

    task automatic m_step();
        if (!m_run) begin m_run = 1; return; end
        if (mE_v && x_pass) begin
            if (x_we) m_regs[x_idx] = x_data;
            if (x_flw) m_fl = x_fl;
        end
        if (mE_v && x_pass && x_take) begin
            m_f = x_tgt; m_mode = x_mode; mD_v = 0; mE_v = 0;
        end else begin
            mE_v = mD_v; mE_a = mD_a; mD_v = 1; mD_a = m_f;
            m_f = m_f + (m_mode ? 2 : 4);
        end
    endtask

    // Capture writes seen at the commit port.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (cnt_w[wr_idx] == 0) first_w[wr_idx] = wr_data;
            last_w[wr_idx] = wr_data;
            cnt_w[wr_idx]++;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) hmem[i] = 16'hF000;
        for (int i = 0; i < 16; i++) begin
            cnt_w[i] = 0; first_w[i] = 0; last_w[i] = 0; m_regs[i] = 0;
        end
        // Wide-mode section.
        put_w(32'h00, enc_w(14, 0, 1, 0, 5));
        put_w(32'h04, enc_w(14, 4, 2, 0, 0));
        put_w(32'h08, enc_w(14, 5, 3, 15, 0));
        put_w(32'h0C, enc_w(14, 3, 0, 1, 5));
        put_w(32'h10, enc_w(1, 0, 4, 0, 7));
        put_w(32'h14, enc_w(0, 0, 5, 0, 9));
        put_w(32'h18, enc_w(14, 2, 6, 1, 6));
        put_w(32'h1C, enc_w(11, 0, 7, 0, 1));
        put_w(32'h20, enc_w(10, 0, 7, 0, 2));
        put_w(32'h24, enc_w(14, 7, 0, 0, 16'h0014));
        put_w(32'h28, enc_w(14, 0, 8, 0, 16'h0BAD));
        put_w(32'h2C, enc_w(14, 0, 8, 0, 16'h0BAD));
        put_w(32'h40, enc_w(14, 1, 9, 6, 1));
        put_w(32'h44, enc_w(2, 0, 10, 0, 3));
        put_w(32'h48, enc_w(14, 0, 13, 0, 16'h00A0));
        put_w(32'h4C, enc_w(14, 0, 11, 0, 16'h0061));
        put_w(32'h50, enc_w(14, 8, 0, 11, 0));
        put_w(32'h54, enc_w(14, 0, 12, 0, 16'h0BAD));
        put_w(32'h58, enc_w(14, 0, 12, 0, 16'h0BAD));
        // Compact-mode section.
        put_c(32'h60, enc_c(14, 4, 2, 0));
        put_c(32'h62, enc_c(14, 4, 3, 0));
        put_c(32'h64, enc_c(14, 5, 4, 15));
        put_c(32'h66, enc_c(14, 0, 5, 0));
        put_c(32'h68, enc_c(14, 9, 5, 4));
        put_c(32'h6A, enc_c(14, 0, 6, 1));
        put_c(32'h6C, enc_c(14, 0, 6, 1));
        put_c(32'h74, enc_c(14, 7, 0, 2));
        put_c(32'h76, enc_c(14, 0, 8, 1));
        put_c(32'h78, enc_c(14, 0, 8, 1));
        put_c(32'h7C, enc_c(14, 10, 5, 4));
        put_c(32'h7E, enc_c(14, 0, 6, 3));
        put_c(32'h80, enc_c(14, 8, 13, 0));
        put_c(32'h82, enc_c(14, 0, 8, 2));
        put_c(32'h84, enc_c(14, 0, 8, 2));
        // Back in wide mode.
        put_w(32'hA0, enc_w(1, 6, 0, 0, 16'h0040));
        put_w(32'hA4, enc_w(14, 0, 12, 0, 16'h0055));
        put_w(32'hA8, enc_w(14, 6, 0, 0, 16'hFFF8));

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_run = 0; m_mode = 0; mD_v = 0; mE_v = 0; m_f = 0; mD_a = 0; mE_a = 0; m_fl = 0;
        // R8: reset state at the ports.
        chk(imem_addr == 0, "R8 reset fetch address", imem_addr, 0);
        chk(imem_req == 0, "R8 reset fetch valid", 32'(imem_req), 0);
        chk(ret_valid == 0, "R8 reset execute empty", 32'(ret_valid), 0);
        chk(flags == 0, "R8 reset flags", 32'(flags), 0);
        for (int cyc = 0; cyc < 120; cyc++) begin
            m_compare();
            m_step();
            @(negedge clk);
        end
        // Fixed-value checks on observed writes.
        chk(first_w[2] == 32'h0C, "R2 wide ADR sees addr+8", first_w[2], 32'h0C);
        chk(first_w[3] == 32'h10, "R2 wide read of register 15", first_w[3], 32'h10);
        chk(last_w[2] == 32'h64, "R4 compact ADR at aligned address", last_w[2], 32'h64);
        chk(last_w[3] == 32'h64, "R4 compact ADR at unaligned address", last_w[3], 32'h64);
        chk(last_w[4] == 32'h68, "R4 compact read of register 15", last_w[4], 32'h68);
        chk(cnt_w[4] == 1, "R5 failed NE wrote nothing", 32'(cnt_w[4]), 1);
        chk(first_w[5] == 9, "R5 passed EQ wrote", first_w[5], 9);
        chk(cnt_w[7] == 1 && last_w[7] == 1, "R5 LT taken, GE skipped", last_w[7], 1);
        chk(first_w[6] == 32'hFFFF_FFFF, "R11 SUBS result", first_w[6], 32'hFFFF_FFFF);
        chk(first_w[14] == 32'h28, "R9 wide link value", first_w[14], 32'h28);
        chk(last_w[14] == 32'h76, "R9 compact link value", last_w[14], 32'h76);
        chk(cnt_w[8] == 0, "R6 flushed instructions never wrote", 32'(cnt_w[8]), 0);
        chk(cnt_w[6] == 2 && last_w[6] == 3, "R3 CBZ target and CBNZ fall-through", last_w[6], 3);
        chk(cnt_w[12] == 1 && last_w[12] == 32'h55, "R10 return to wide mode", last_w[12], 32'h55);
        chk(last_w[9] == 0 && last_w[10] == 3, "R11 ADDS carry drives CS", last_w[10], 3);
        chk(flags == 4'b0110, "R11 final flags", 32'(flags), 32'b0110);
        chk(cnt_w[15] == 0, "R12 no write to register 15", 32'(cnt_w[15]), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule